// File: doc/BRIEF.md
# Priority-Grouped Interrupt Arbiter

This block tracks a set of interrupt lines. For each line it keeps an enable bit, a pending bit, an active bit and a 4-bit priority, where a smaller number means a more urgent line. A 3-bit grouping field, set at run time, decides how many of the upper priority bits form the preemption level. The remaining lower bits form the subpriority. Software reaches all of this through a single-cycle write port that carries an operation code, a line number and a data nibble. The pending and active vectors are visible at the ports.

A combinational picker finds the most urgent line that is both pending and enabled. The block raises `req_o` for that line in two cases: nothing is active, or the line's preemption level is strictly lower than the level of the line that entered service most recently. An `ack_i` taken while `req_o` is high pushes the winner onto an internal service stack. That clears its pending bit and sets its active bit. `eoi_i` pops the stack and clears the active bit of the line on top.

A small state machine with two states, `ST_IDLE` (stack empty) and `ST_SERVE` (one or more lines in service), governs the stack. It has three transitions:
- `IDLE_TO_SERVE` is taken on an accepted acknowledge.
- `SERVE_TO_IDLE` is taken when the last entry is popped.
- `SERVE_HOLD` covers nesting and partial unwinding.

Top module: `prio_group_arb`

## Requirements
- R1: After reset, `pending_o`, `active_o` and `req_o` are all zero, every priority is zero, the grouping is zero and every line is disabled.
- R2: A write with `wr_en_i` high acts on line `wr_line_i` at the next clock edge. The operation codes are:
  - 3 sets the line's pending bit.
  - 4 clears the line's pending bit.
  - 5 enables the line.
  - 6 disables the line.
  - 2 loads `wr_data_i` as the line's priority.
  - 1 loads `wr_data_i[2:0]` as the grouping.
  - 0 and 7 do nothing.
- R3: A disabled line keeps its pending bit, and that bit stays visible on `pending_o`. The line never wins arbitration and never causes `req_o`.
- R4: The winner is the enabled pending line with the numerically lowest 4-bit priority. A tie goes to the lowest line number. `req_line_o` names the winner while `req_o` is high.
- R5: With grouping g in 0..4, the preemption level is the priority shifted right by 4−g. Grouping values 5 to 7 act as 4.
- R6: While no line is active, `req_o` is high whenever at least one line is both enabled and pending.
- R7: While lines are active, `req_o` is high only if the winner's preemption level is strictly lower than that of the most recently activated line. Equal levels never request.
- R8: With grouping 0, `req_o` stays low whenever any line is active.
- R9: `ack_i` while `req_o` is high and `eoi_i` is low has two effects at the next edge: the winner's pending bit clears and its active bit sets. In all other cases `ack_i` is ignored. A pending write in the same cycle takes effect after the acknowledge clear.
- R10: `eoi_i` clears the active bit of the most recently activated line still in service. It is ignored when nothing is active. When `eoi_i` and `ack_i` arrive together, only the end-of-service is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_op_i | input | 3 | Write operation code |
| wr_line_i | input | $clog2(NUM_LINES) | Line addressed by the write |
| wr_data_i | input | 4 | Priority or grouping value |
| ack_i | input | 1 | Accept the requested line into service |
| eoi_i | input | 1 | End of service for the newest active line |
| req_o | output | 1 | Entry request for the winner |
| req_line_o | output | $clog2(NUM_LINES) | Winning line number |
| pending_o | output | NUM_LINES | Pending bits |
| active_o | output | NUM_LINES | Active bits |

## Verification
The hardest situation to reach is a service stack two or more deep. In that state the newest active line and a pending line share a preemption level but differ in subpriority, and the grouping is then changed. Only a change of split at that point turns a blocked line into a requester. Directed sequences build that nesting by hand: they program priorities such as 0101 against 0100 and step the grouping through 2, 3 and 4. A long random run then raises the acknowledge rate, so that nesting and regrouping recur with arbitrary priorities.

// File: rtl/prio_group_arb_pkg.sv
package prio_group_arb_pkg;
    localparam int PRIO_W = 4;
    localparam int GRP_W  = 3;

    typedef enum logic [2:0] {
        OP_NOP   = 3'd0,
        OP_GROUP = 3'd1,
        OP_PRIO  = 3'd2,
        OP_SETP  = 3'd3,
        OP_CLRP  = 3'd4,
        OP_SETE  = 3'd5,
        OP_CLRE  = 3'd6,
        OP_NOP7  = 3'd7
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } svc_state_e;

    // Upper bits that form the preemption level for a given grouping.
    function automatic logic [PRIO_W-1:0] preempt_of(input logic [PRIO_W-1:0] p,
                                                    input logic [GRP_W-1:0]  g);
        int keep;
        keep = (int'(g) > PRIO_W) ? PRIO_W : int'(g);
        return p >> (PRIO_W - keep);
    endfunction
endpackage

// File: rtl/pga_regs.sv
module pga_regs
    import prio_group_arb_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  op_e                        wr_op,
    input  logic [LW-1:0]              wr_line,
    input  logic [PRIO_W-1:0]          wr_data,
    input  logic                       clr_en,
    input  logic [LW-1:0]              clr_line,
    output logic [N-1:0]               pend_q,
    output logic [N-1:0]               en_q,
    output logic [N-1:0][PRIO_W-1:0]   prio_q,
    output logic [GRP_W-1:0]           grp_q
);
    logic line_ok;
    assign line_ok = (int'(wr_line) < N);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= '0;
            prio_q <= '0;
            grp_q  <= '0;
        end else begin
            if (clr_en) pend_q[clr_line] <= 1'b0;
            if (wr_en) begin
                case (wr_op)
                    OP_GROUP: grp_q <= wr_data[GRP_W-1:0];
                    OP_PRIO:  if (line_ok) prio_q[wr_line] <= wr_data;
                    OP_SETP:  if (line_ok) pend_q[wr_line] <= 1'b1;
                    OP_CLRP:  if (line_ok) pend_q[wr_line] <= 1'b0;
                    OP_SETE:  if (line_ok) en_q[wr_line]   <= 1'b1;
                    OP_CLRE:  if (line_ok) en_q[wr_line]   <= 1'b0;
                    default:  ;
                endcase
            end
        end
    end

    // R2: a pending-set write shows up on the next cycle
    p_setp_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_SETP && line_ok) |=> pend_q[$past(wr_line)]);
endmodule

// File: rtl/pga_pick.sv
module pga_pick
    import prio_group_arb_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]              pend,
    input  logic [N-1:0]              en,
    input  logic [N-1:0][PRIO_W-1:0]  prio,
    output logic                      found,
    output logic [LW-1:0]             line,
    output logic [PRIO_W-1:0]         best
);
    // Full-priority order equals preemption-then-subpriority order,
    // and the strict compare keeps the lowest index on ties.
    always_comb begin
        found = 1'b0;
        line  = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && en[i] && (!found || prio[i] < best)) begin
                found = 1'b1;
                best  = prio[i];
                line  = LW'(i);
            end
        end
    end
endmodule

// File: rtl/pga_stack.sv
module pga_stack
    import prio_group_arb_pkg::*;
#(
    parameter int N  = 8,
    parameter int LW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [LW-1:0]  push_line,
    input  logic           pop,
    output logic [N-1:0]   active_q,
    output logic [LW-1:0]  top_line,
    output logic           busy
);
    localparam int DW = $clog2(N + 1);

    svc_state_e     state_q, state_d;
    logic [LW-1:0]  slot_q [N];
    logic [DW-1:0]  depth_q;
    logic           do_pop, do_push;

    assign do_pop  = pop && (depth_q != '0);
    assign do_push = push && !do_pop && (depth_q != DW'(N));

    always_comb begin
        top_line = '0;
        for (int i = 0; i < N; i++) begin
            if ((DW'(i) + DW'(1)) == depth_q) top_line = slot_q[i];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (do_push) state_d = ST_SERVE;                       // IDLE_TO_SERVE
            ST_SERVE: if (do_pop && depth_q == DW'(1)) state_d = ST_IDLE;   // SERVE_TO_IDLE
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        busy = (state_q == ST_SERVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q  <= '0;
            active_q <= '0;
            for (int i = 0; i < N; i++) slot_q[i] <= '0;
        end else if (do_pop) begin
            active_q[top_line] <= 1'b0;
            depth_q            <= depth_q - DW'(1);
        end else if (do_push) begin
            for (int i = 0; i < N; i++) begin
                if (DW'(i) == depth_q) slot_q[i] <= push_line;
            end
            active_q[push_line] <= 1'b1;
            depth_q             <= depth_q + DW'(1);
        end
    end

    // R9: an accepted entry marks the line active
    p_push_sets_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && depth_q != DW'(N)) |=> active_q[$past(push_line)]);
    // R10: end-of-service retires the newest active line
    p_pop_clears_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && busy) |=> !active_q[$past(top_line)]);
    // R10: idle state means nothing is in service
    p_idle_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (active_q == '0));
    p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q <= DW'(N));
endmodule

// File: rtl/prio_group_arb.sv
module prio_group_arb
    import prio_group_arb_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int LW = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [2:0]            wr_op_i,
    input  logic [LW-1:0]         wr_line_i,
    input  logic [PRIO_W-1:0]     wr_data_i,
    input  logic                  ack_i,
    input  logic                  eoi_i,
    output logic                  req_o,
    output logic [LW-1:0]         req_line_o,
    output logic [NUM_LINES-1:0]  pending_o,
    output logic [NUM_LINES-1:0]  active_o
);
    logic [NUM_LINES-1:0]              pend, en;
    logic [NUM_LINES-1:0][PRIO_W-1:0]  prio;
    logic [GRP_W-1:0]                  grp;
    logic                              win_found, busy, ack_fire, pop;
    logic [LW-1:0]                     win_line, top_line;
    logic [PRIO_W-1:0]                 win_prio, win_pre, top_pre;
    op_e                               op;

    assign op       = op_e'(wr_op_i);
    assign pop      = eoi_i && busy;
    assign ack_fire = ack_i && req_o && !eoi_i;

    pga_regs #(.N(NUM_LINES), .LW(LW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_op(op), .wr_line(wr_line_i), .wr_data(wr_data_i),
        .clr_en(ack_fire), .clr_line(win_line),
        .pend_q(pend), .en_q(en), .prio_q(prio), .grp_q(grp)
    );

    pga_pick #(.N(NUM_LINES), .LW(LW)) u_pick (
        .pend(pend), .en(en), .prio(prio),
        .found(win_found), .line(win_line), .best(win_prio)
    );

    pga_stack #(.N(NUM_LINES), .LW(LW)) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(ack_fire), .push_line(win_line), .pop(pop),
        .active_q(active_o), .top_line(top_line), .busy(busy)
    );

    assign win_pre    = preempt_of(win_prio, grp);
    assign top_pre    = preempt_of(prio[top_line], grp);
    assign req_o      = win_found && (!busy || (win_pre < top_pre));
    assign req_line_o = win_line;
    assign pending_o  = pend;

    // R3: only an enabled pending line can request
    p_req_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (pend[req_line_o] && en[req_line_o]));
    // R8: grouping zero forbids preemption
    p_group0_no_preempt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == '0 && active_o != '0) |-> !req_o);
    // R9: accepted line leaves the pending set unless rewritten
    p_ack_clears_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_fire && !(wr_en_i && op == OP_SETP && wr_line_i == req_line_o))
        |=> !pending_o[$past(req_line_o)]);
    // R6: idle with an eligible line requests
    p_idle_requests_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o == '0 && (pend & en) != '0) |-> req_o);
endmodule

// File: tb/prio_group_arb_bench.sv
module prio_group_arb_bench;
    localparam int N  = 8;
    localparam int LW = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en_i = 0, ack_i = 0, eoi_i = 0;
    logic [2:0] wr_op_i = 0;
    logic [LW-1:0] wr_line_i = 0;
    logic [3:0] wr_data_i = 0;
    logic req_o;
    logic [LW-1:0] req_line_o;
    logic [N-1:0] pending_o, active_o;

    int checks = 0, fails = 0;
    bit done = 0;

    // reference state
    bit m_pend[N], m_en[N], m_act[N];
    int m_prio[N], m_grp, m_stk[N], m_depth;

    always #4 clk = ~clk;

    prio_group_arb #(.NUM_LINES(N)) u_prio_group_arb (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_op_i(wr_op_i),
        .wr_line_i(wr_line_i), .wr_data_i(wr_data_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .req_o(req_o), .req_line_o(req_line_o), .pending_o(pending_o), .active_o(active_o)
    );

    function automatic int pre(int p, int g);
        int k;
        k = (g > 4) ? 4 : g;
        return p >> (4 - k);
    endfunction

    function automatic int win_line();
        int w;
        w = -1;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_en[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
        return w;
    endfunction

    function automatic bit exp_req();
        int w;
        w = win_line();
        if (w < 0) return 0;
        if (m_depth == 0) return 1;
        return pre(m_prio[w], m_grp) < pre(m_prio[m_stk[m_depth-1]], m_grp);
    endfunction

    function automatic logic [N-1:0] vec(input bit b[N]);
        logic [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = b[i];
        return v;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(string tag, bit wr, int op, int ln, int dat, bit a, bit e);
        bit r, ae, ee;
        int w;
        @(negedge clk);
        wr_en_i = wr; wr_op_i = 3'(op); wr_line_i = LW'(ln); wr_data_i = 4'(dat);
        ack_i = a; eoi_i = e;
        #1;
        r = exp_req();
        w = win_line();
        chk(tag, "req_o", int'(req_o), int'(r));
        if (r) chk(tag, "req_line_o", int'(req_line_o), w);
        chk(tag, "pending_o", int'(pending_o), int'(vec(m_pend)));
        chk(tag, "active_o", int'(active_o), int'(vec(m_act)));
        ee = e && (m_depth > 0);
        ae = a && r && !e;
        if (ee) begin
            m_act[m_stk[m_depth-1]] = 0;
            m_depth--;
        end else if (ae) begin
            m_pend[w] = 0;
            if (m_depth < N) begin
                m_stk[m_depth] = w;
                m_act[w] = 1;
                m_depth++;
            end
        end
        if (wr) begin
            case (op)
                1: m_grp = dat & 7;
                2: m_prio[ln] = dat;
                3: m_pend[ln] = 1;
                4: m_pend[ln] = 0;
                5: m_en[ln] = 1;
                6: m_en[ln] = 0;
                default: ;
            endcase
        end
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int seed;
        int r_op;
        seed = $urandom(32'd2024);
        m_grp = 0; m_depth = 0;
        for (int i = 0; i < N; i++) begin
            m_pend[i] = 0; m_en[i] = 0; m_act[i] = 0; m_prio[i] = 0; m_stk[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        idle("R1");                          // reset state
        step("R2", 1, 5, 2, 0, 0, 0);        // enable line 2
        step("R2", 1, 3, 2, 0, 0, 0);        // set pending
        step("R2", 1, 4, 2, 0, 0, 0);        // clear pending
        idle("R2");
        step("R3", 1, 3, 5, 0, 0, 0);        // pend on disabled line
        idle("R3");
        step("R3", 1, 5, 5, 0, 0, 0);
        step("R3", 1, 6, 5, 0, 0, 0);
        idle("R3");
        step("R3", 1, 4, 5, 0, 0, 0);
        step("R4", 1, 1, 0, 4, 0, 0);        // grouping 4
        step("R4", 1, 2, 1, 3, 0, 0);
        step("R4", 1, 2, 3, 3, 0, 0);
        step("R4", 1, 2, 6, 1, 0, 0);
        step("R4", 1, 5, 1, 0, 0, 0);
        step("R4", 1, 5, 3, 0, 0, 0);
        step("R4", 1, 5, 6, 0, 0, 0);
        step("R4", 1, 3, 3, 0, 0, 0);
        step("R4", 1, 3, 1, 0, 0, 0);
        idle("R4");                          // tie -> line 1
        step("R4", 1, 3, 6, 0, 0, 0);
        idle("R4");                          // line 6 wins
        step("R9", 0, 0, 0, 0, 1, 0);        // accept line 6
        idle("R9");
        step("R9", 0, 0, 0, 0, 1, 0);        // ack without request
        idle("R9");
        step("R7", 1, 2, 0, 1, 0, 0);
        step("R7", 1, 5, 0, 0, 0, 0);
        step("R7", 1, 3, 0, 0, 0, 0);
        idle("R7");                          // equal level, no request
        step("R7", 1, 2, 0, 0, 0, 0);
        idle("R7");                          // strictly lower, request
        step("R9", 0, 0, 0, 0, 1, 0);        // nest line 0
        idle("R9");
        step("R10", 0, 0, 0, 0, 0, 1);       // retire line 0
        idle("R10");
        step("R10", 0, 0, 0, 0, 1, 1);       // both: only retire
        idle("R6");
        step("R10", 0, 0, 0, 0, 0, 1);       // nothing active
        idle("R10");
        step("R8", 1, 1, 0, 0, 0, 0);        // grouping 0
        step("R8", 0, 0, 0, 0, 1, 0);
        step("R8", 1, 2, 0, 0, 0, 0);
        step("R8", 1, 3, 0, 0, 0, 0);
        idle("R8");
        step("R5", 1, 1, 0, 2, 0, 0);
        idle("R5");
        step("R5", 1, 2, 1, 5, 0, 0);
        idle("R5");
        step("R5", 1, 1, 0, 3, 0, 0);
        idle("R5");
        step("R5", 1, 2, 0, 4, 0, 0);
        step("R5", 1, 1, 0, 2, 0, 0);
        idle("R5");
        step("R5", 1, 1, 0, 4, 0, 0);
        idle("R5");
        step("R5", 1, 1, 0, 6, 0, 0);        // 6 acts as 4
        idle("R5");
        step("R9", 1, 3, 1, 0, 1, 0);        // write-after-ack ordering

        for (int n = 0; n < 6000; n++) begin
            r_op = int'($urandom_range(0, 9));
            if (r_op < 7)
                step("R4", 1, r_op, int'($urandom_range(0, N-1)), int'($urandom_range(0, 15)),
                     ($urandom_range(0, 2) == 0), ($urandom_range(0, 6) == 0));
            else
                step("R7", 0, 0, 0, 0, (r_op != 9), (r_op == 9));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule